// File: doc/BRIEF.md
# Sample-Period Serial Port with Early DAC Update

This block is the slave side of a codec-style serial link to a host signal processor. Its serial clock is the system clock `clk`. A free-running sample counter divides time into periods of `PERIOD` clocks. At the start of each period the block raises `adcFs` for one clock and captures `adcWord`. It then shifts that word out on `sdo`, most significant bit first, over the next 16 clocks.

In the other direction, the host sends a 16-bit word on `sdi`, framed by its own one-clock pulse on `dacFs`. The block gathers the bits into a serial register and copies the finished word into a holding register. Receiving a word does not change `dacOut`. `dacOut` is reloaded from the holding register once per period, at a scheduled point. By default that point is the clock edge just before the next frame sync. A 4-bit advance value moves it earlier, 8 clocks per step, so a host that answers quickly can have its sample applied sooner. `dacLoad` pulses in the cycle where each reload becomes visible.

Top module: `codecSerialPort`

## Requirements
- R1: `adcFs` is high in the first cycle after reset is released and then for exactly one cycle every `PERIOD` (256) cycles. Counter value 0 marks this sync cycle.
- R2: `adcWord` is captured on the rising edge that ends the sync cycle. In the 16 cycles after it, `sdo` carries bits 15 down to 0 in that order. `sdo` is low in every other cycle.
- R3: `dacFs` and `sdi` are sampled on the falling edge of `clk`. A high `dacFs` sample starts a reception. The `sdi` samples of the next 16 cycles form the word, first bit as bit 15. The word goes into the holding register on the rising edge that ends the 16th bit cycle.
- R4: `dacOut` changes only by a reload from the holding register. `dacLoad` is high exactly in the cycle in which a reloaded value first appears.
- R5: With advance 0, the reload happens on the rising edge that ends counter value `PERIOD`-1. A new value therefore appears in the same cycle as `adcFs`.
- R6: The advance value `a` on `dacAdvance` is captured on the rising edge that ends the sync cycle and holds for that period. The reload then happens on the rising edge that ends counter value `PERIOD`-1-8·`a`.
- R7: A scheduled reload edge can fall while a reception is in progress, meaning on the edges that end the 16 bit cycles. In that case the reload is deferred to the rising edge after the one that completes reception, so the new word is applied. A reload edge that ends the `dacFs` cycle itself is not deferred and applies the older word.
- R8: Exactly one reload happens in each period. If no new word has arrived, `dacOut` keeps its value and `dacLoad` still pulses.
- R9: A high `dacFs` sample while a reception is in progress is ignored, and the word being received is unaffected.
- R10: A synchronous active-high `rst` clears the counter, the advance value, the shift, holding and output registers, `sdo` and `dacLoad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous reset, active high |
| adcWord | input | 16 | Sample to transmit, captured at the end of the sync cycle |
| dacAdvance | input | 4 | Reload advance in steps of 8 clocks |
| adcFs | output | 1 | Output frame sync, one cycle per period |
| sdo | output | 1 | Serial data out, MSB first |
| dacFs | input | 1 | Input frame sync from the host |
| sdi | input | 1 | Serial data in, MSB first |
| dacOut | output | 16 | DAC output register |
| dacLoad | output | 1 | High in the cycle a reload becomes visible |

## Verification
The hardest case is a scheduled reload edge that lands inside a running reception. Both the clamp and its boundary depend on the offset between the host's frame and the internal counter. That counter is not visible at the ports.

The bench keeps its own copy of the counter, derived from reset release, and of the captured advance value. With these it starts host frames at chosen counter values. One frame puts the reload point in the middle of the bit window. Another starts one cycle too early for the window to cover the reload point, and a third starts exactly on it. For each frame the bench predicts the absolute cycle in which `dacOut` must change.

// File: rtl/codecSerialPortPkg.sv
package codecSerialPortPkg;
  // strobes issued by the sequencer to the datapath for the current cycle
  typedef struct packed {
    logic loadAdc;  // capture the transmit word (sync cycle)
    logic loadDac;  // reload dacOut from the holding register
  } ctrlStrobes_t;
endpackage

// File: rtl/codecSerialPortCtrl.sv
module codecSerialPortCtrl
  import codecSerialPortPkg::*;
#(
  parameter int PERIOD   = 256,
  parameter int ADV_W    = 4,
  parameter int ADV_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADV_W-1:0] advIn,
  input  logic             rxBusy,
  output logic             syncCycle,
  output ctrlStrobes_t     strobes
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int LAST  = PERIOD - 1;

  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] loadPoint;
  logic [ADV_W-1:0] advReg;
  logic             pending;
  logic             atLoadPoint;
  logic             fire;

  // scheduled reload position, pulled earlier by the latched advance
  always_comb begin
    loadPoint   = CNT_W'(LAST - int'(advReg) * ADV_STEP);
    atLoadPoint = (sampleCnt == loadPoint);
    // a reload never lands inside a running reception: it waits for it
    fire        = (atLoadPoint || pending) && !rxBusy;
    syncCycle   = (sampleCnt == '0);
    strobes.loadAdc = syncCycle;
    strobes.loadDac = fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      advReg    <= '0;
      pending   <= 1'b0;
    end else begin
      sampleCnt <= (sampleCnt == CNT_W'(LAST)) ? '0 : sampleCnt + 1'b1;
      if (syncCycle) advReg <= advIn;
      if (fire)
        pending <= 1'b0;
      else if (atLoadPoint && rxBusy)
        pending <= 1'b1;
    end
  end
endmodule

// File: rtl/codecSerialPortData.sv
module codecSerialPortData
  import codecSerialPortPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] adcWord,
  input  logic              sdi,
  input  logic              dacFs,
  output logic              sdo,
  output logic              rxBusy,
  output logic [WORD_W-1:0] dacOut,
  output logic              dacLoad
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic              sdiSamp;
  logic              fsSamp;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] holdReg;
  logic [BIT_W-1:0]  bitCnt;

  // host-side inputs are taken on the falling edge, mid-bit
  always_ff @(negedge clk) begin
    if (rst) begin
      sdiSamp <= 1'b0;
      fsSamp  <= 1'b0;
    end else begin
      sdiSamp <= sdi;
      fsSamp  <= dacFs;
    end
  end

  // transmit shifter: zero fill leaves sdo low once the word is out
  always_ff @(posedge clk) begin
    if (rst)
      txShift <= '0;
    else if (strobes.loadAdc)
      txShift <= adcWord;
    else
      txShift <= {txShift[WORD_W-2:0], 1'b0};
  end
  assign sdo = txShift[WORD_W-1];

  // receiver: a sync pulse arms it, WORD_W bits fill it
  always_ff @(posedge clk) begin
    if (rst) begin
      rxBusy  <= 1'b0;
      bitCnt  <= '0;
      rxShift <= '0;
      holdReg <= '0;
    end else if (!rxBusy) begin
      if (fsSamp) begin
        rxBusy <= 1'b1;
        bitCnt <= '0;
      end
    end else begin
      rxShift <= {rxShift[WORD_W-2:0], sdiSamp};
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) begin
        rxBusy  <= 1'b0;
        holdReg <= {rxShift[WORD_W-2:0], sdiSamp};
      end
    end
  end

  // output register, reloaded once per period by the sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      dacOut  <= '0;
      dacLoad <= 1'b0;
    end else begin
      dacLoad <= strobes.loadDac;
      if (strobes.loadDac) dacOut <= holdReg;
    end
  end
endmodule

// File: rtl/codecSerialPort.sv
module codecSerialPort
  import codecSerialPortPkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PERIOD   = 256,
  parameter int ADV_W    = 4,
  parameter int ADV_STEP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] adcWord,
  input  logic [ADV_W-1:0]  dacAdvance,
  output logic              adcFs,
  output logic              sdo,
  input  logic              dacFs,
  input  logic              sdi,
  output logic [WORD_W-1:0] dacOut,
  output logic              dacLoad
);
  ctrlStrobes_t strobes;
  logic         rxBusy;

  codecSerialPortCtrl #(
    .PERIOD  (PERIOD),
    .ADV_W   (ADV_W),
    .ADV_STEP(ADV_STEP)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .advIn    (dacAdvance),
    .rxBusy   (rxBusy),
    .syncCycle(adcFs),
    .strobes  (strobes)
  );

  codecSerialPortData #(
    .WORD_W(WORD_W)
  ) data (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .adcWord(adcWord),
    .sdi    (sdi),
    .dacFs  (dacFs),
    .sdo    (sdo),
    .rxBusy (rxBusy),
    .dacOut (dacOut),
    .dacLoad(dacLoad)
  );
endmodule

// File: rtl/codecSerialPortChk.sv
module codecSerialPortChk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] adcWord,
  input logic              adcFs,
  input logic              sdo,
  input logic [WORD_W-1:0] dacOut,
  input logic              dacLoad
);
  // R1
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    adcFs |=> !adcFs);

  // R2
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    adcFs |-> !sdo);

  // R2
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    adcFs |=> (sdo == $past(adcWord[WORD_W-1])));

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dacLoad && !$past(rst)) |-> $stable(dacOut));

  // R8
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    dacLoad |=> !dacLoad);
endmodule

bind codecSerialPort codecSerialPortChk #(.WORD_W(WORD_W)) chk (
  .clk    (clk),
  .rst    (rst),
  .adcWord(adcWord),
  .adcFs  (adcFs),
  .sdo    (sdo),
  .dacOut (dacOut),
  .dacLoad(dacLoad)
);

// File: tb/codecSerialPort_test.sv
module codecSerialPort_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] adcWord = '0;
  logic [3:0]  dacAdvance = '0;
  logic        dacFs = 1'b0;
  logic        sdi = 1'b0;
  logic        adcFs, sdo, dacLoad;
  logic [15:0] dacOut;

  always #4 clk = ~clk;

  codecSerialPort uut (
    .clk(clk), .rst(rst), .adcWord(adcWord), .dacAdvance(dacAdvance),
    .adcFs(adcFs), .sdo(sdo), .dacFs(dacFs), .sdi(sdi),
    .dacOut(dacOut), .dacLoad(dacLoad)
  );

  int passCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  // bench's own model of the sample counter and latched advance
  int         tc = 0;
  int         absCyc = 0;
  logic [3:0] advEff = '0;
  always @(posedge clk) begin
    if (rst) begin
      tc <= 0; absCyc <= 0; advEff <= '0;
    end else begin
      tc <= (tc == 255) ? 0 : tc + 1;
      absCyc <= absCyc + 1;
      if (tc == 0) advEff <= dacAdvance;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] adcQ[$];
  int          expCyc[$];
  logic [15:0] expVal[$];
  string       expReq[$];
  int          frameNo = 0;

  task automatic pushAdc(input logic [15:0] w);
    adcWord = w;
    adcQ.push_back(w);
  endtask

  task automatic expectDac(input int cyc, input logic [15:0] v, input string req);
    expCyc.push_back(cyc);
    expVal.push_back(v);
    expReq.push_back(req);
  endtask

  // ADC driver: fresh word each sync cycle (R2)
  always @(negedge clk) begin
    if (rst) adcQ.delete();
    else if (tc == 0) begin
      pushAdc(16'hB38E ^ 16'(frameNo * 40503));
      frameNo++;
    end
  end

  // monitor
  logic [15:0] gotBits = '0;
  logic [15:0] lastDac = '0;
  always @(negedge clk) begin
    if (rst) begin
      gotBits = '0;
      lastDac = dacOut;
    end else begin
      if (tc == 0) check(adcFs == 1'b1, "R1", "adcFs in sync cycle", adcFs, 1);
      if (tc == 9) check(adcFs == 1'b0, "R1", "adcFs mid period", adcFs, 0);
      if (tc >= 1 && tc <= 16) gotBits = {gotBits[14:0], sdo};
      if (tc == 16) begin
        if (adcQ.size() == 0) check(0, "R2", "no expected adc word", gotBits, 0);
        else begin
          logic [15:0] w;
          w = adcQ.pop_front();
          check(gotBits == w, "R2", "sdo word", gotBits, w);
        end
      end
      if (tc == 40) check(sdo == 1'b0, "R2", "sdo idle", sdo, 0);
      if (dacOut !== lastDac) begin
        check(dacLoad == 1'b1, "R4", "dacLoad on change", dacLoad, 1);
        if (expCyc.size() == 0)
          check(0, "R8", "unexpected dacOut change", dacOut, lastDac);
        else begin
          int c; logic [15:0] v; string r;
          c = expCyc.pop_front(); v = expVal.pop_front(); r = expReq.pop_front();
          check(absCyc == c, r, "dacOut change cycle", absCyc, c);
          check(dacOut == v, r, "dacOut value", dacOut, v);
        end
        lastDac = dacOut;
      end
    end
  end

  task automatic waitTc(input int c);
    do begin
      @(posedge clk); #1;
    end while (tc != c);
  endtask

  // host frame (R3); extraFs raises dacFs again mid-word (R9)
  task automatic sendDac(input logic [15:0] w, input bit extraFs);
    int c, start, lp, vis;
    string req;
    c = tc; start = absCyc - tc; lp = 255 - 8 * int'(advEff);
    if (lp >= c + 1 && lp <= c + 16) begin vis = absCyc + 18; req = "R7"; end
    else if (lp > c + 16) begin vis = start + lp + 1; req = (advEff == 0) ? "R5" : "R6"; end
    else begin vis = start + 256 + lp + 1; req = "R7"; end
    if (extraFs) req = "R9";
    expectDac(vis, w, req);
    dacFs = 1'b1;
    @(posedge clk); #1;
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      dacFs = (extraFs && i == 10);
      @(posedge clk); #1;
    end
    sdi = 1'b0; dacFs = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dacOut == 16'h0, "R10", "dacOut in reset", dacOut, 0);
    check(sdo == 1'b0, "R10", "sdo in reset", sdo, 0);
    check(dacLoad == 1'b0, "R10", "dacLoad in reset", dacLoad, 0);
    @(posedge clk); #1; rst = 1'b0;

    // R3/R5: default position, applied together with the next sync
    waitTc(40); sendDac(16'h1234, 0);
    waitTc(0);
    waitTc(0); @(negedge clk);
    check(dacLoad == 1'b1 && dacOut == 16'h1234, "R8", "reload without new word",
          dacOut, 16'h1234);

    // R6: advance 3 takes effect in this period
    @(posedge clk); #1; dacAdvance = 4'd3;
    waitTc(0); waitTc(40); sendDac(16'hBEEF, 0);
    waitTc(0); waitTc(232); @(negedge clk);
    check(dacLoad == 1'b1 && dacOut == 16'hBEEF, "R8", "advanced reload, no word",
          dacOut, 16'hBEEF);

    // R7: advance 15, reload point 135
    dacAdvance = 4'd15;
    waitTc(0); waitTc(125); sendDac(16'h5A0F, 0);   // deferred
    waitTc(0); waitTc(118); sendDac(16'hC001, 0);   // window ends just before
    waitTc(0); waitTc(135); sendDac(16'h7E57, 0);   // frame sync on reload edge
    waitTc(0); waitTc(200);

    // R9: repeated sync during reception
    dacAdvance = 4'd0;
    waitTc(0); waitTc(40); sendDac(16'h9999, 1);
    waitTc(0); waitTc(60);
    check(expCyc.size() == 0, "R4", "pending dac changes", expCyc.size(), 0);

    // R10: mid-run reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(dacOut == 16'h0, "R10", "dacOut after reset", dacOut, 0);
    check(dacLoad == 1'b0, "R10", "dacLoad after reset", dacLoad, 0);
    check(adcFs == 1'b1, "R10", "counter cleared", adcFs, 1);
    @(posedge clk); #1; rst = 1'b0;
    waitTc(0); waitTc(50);
    check(dacOut == 16'h0 && expCyc.size() == 0, "R10", "dacOut held after reset",
          dacOut, 0);

    finished = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule